// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause 22 management transactions towards external PHYs. Software configures a clock divider and a preamble option, then writes one 32-bit command word. That word already contains the complete frame: start and opcode, PHY address, register address, turnaround and data. Writing it starts the transaction. The block sends the word out on the serial management pins exactly as written. It adds a run of 32 one bits in front of it when the preamble option is on. For a read it captures the 16 bits the PHY returns.

When a transaction finishes, a sticky completion flag is set. Software clears the flag by writing 1 to it, and it can also be routed to an interrupt output through a mask bit. After a read, the returned value appears in the low half of the command register. Software polls the flag or waits for the interrupt; there is no busy bit.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read 0, MDC is low, the MDIO output enable is low and `irq` is low.
- R2: While a frame is running, MDC toggles every (divider+1) system clocks, so rising edges are 2*(divider+1) clocks apart. While idle, MDC stays low. The divider is bits 6:0 of the control register (address 0).
- R3: A bus write to the data register (address 1) starts a frame. With the preamble off, exactly 32 MDC rising edges occur, and MDIO carries the written word MSB first with the output enable high throughout, for a write frame.
- R4: When control bit 7 is 1, 32 one bits are driven before the command word, giving 64 MDC rising edges.
- R5: MDIO changes only while MDC is low and is stable at every MDC rising edge.
- R6: A frame whose bits 31:28 equal 0x6 is a read. The output enable drops for command bit 16 (the second turnaround bit) and stays low to the end of the frame. The 16 bits sampled on the last 16 MDC rising edges, MSB first, replace data register bits 15:0. Bits 31:16 keep the written value.
- R7: At the end of a frame, bit 0 of the interrupt status register (address 2) becomes 1. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: `irq` equals status bit 0 AND bit 0 of the mask register (address 3).
- R9: A data register write while a frame is in progress is ignored: the running frame and the stored word are not changed.
- R10: When no frame is running, the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench records every MDC rising edge and acts as a PHY that drives response bits after each rising edge. This catches an off-by-one frame length, a preamble that is too short, and a divider whose period is off by one clock.

Read frames check where the output enable falls. If it falls one bit early or late, or if the shift direction is reversed, the returned value comes out shifted or bit-reversed. Read frames also check that the upper half of the data register keeps the command.

A second data write in the middle of a frame must leave both the stored word and the edge count unchanged; a design without a busy guard would restart or corrupt the frame. Writing 0 to the status register must not clear it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_DATA  = 2'd1,
    A_ISTAT = 2'd2,
    A_IMASK = 2'd3
  } reg_addr_e;

  localparam logic [3:0] OP_READ = 4'h6;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap      = run && (cnt_q == div);
  assign tick_rise = wrap && !mdc_q;
  assign tick_fall = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int unsigned CMD_W   = 32,
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned RD_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pre_en,
  input  logic [CMD_W-1:0] cmd,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic             mdio_i,
  output logic             busy,
  output logic             done,
  output logic             done_rd,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [RD_W-1:0]  rx_data
);
  localparam int unsigned SH_W      = CMD_W + PRE_LEN;
  localparam int unsigned CNT_W     = $clog2(SH_W + 1);
  localparam int unsigned TA2_LEFT  = RD_W + 1;

  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic [RD_W-1:0]  rx_q, rx_d;
  logic             last_bit;

  assign last_bit = busy_q && tick_fall && (left_q == CNT_W'(1));
  assign done     = last_bit;
  assign done_rd  = rd_q;
  assign busy     = busy_q;
  assign rx_data  = rx_q;
  assign mdio_o   = busy_q ? sh_q[SH_W-1] : 1'b1;
  assign mdio_oe  = busy_q && !(rd_q && (left_q <= CNT_W'(TA2_LEFT)));

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    rx_d   = rx_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = (cmd[CMD_W-1 -: 4] == OP_READ);
      if (pre_en) begin
        sh_d   = {{PRE_LEN{1'b1}}, cmd};
        left_d = CNT_W'(SH_W);
      end else begin
        sh_d   = {cmd, {PRE_LEN{1'b0}}};
        left_d = CNT_W'(CMD_W);
      end
    end else if (busy_q) begin
      if (tick_rise) rx_d = {rx_q[RD_W-2:0], mdio_i};
      if (tick_fall) begin
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          sh_d   = sh_q << 1;
          left_d = left_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      rx_q   <= rx_d;
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W = 7,
  parameter int unsigned CMD_W = 32,
  parameter int unsigned RD_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] rdata,
  input  logic             busy,
  input  logic             done,
  input  logic             done_rd,
  input  logic [RD_W-1:0]  rx_data,
  output logic [DIV_W-1:0] div,
  output logic             pre_en,
  output logic [CMD_W-1:0] cmd,
  output logic             start,
  output logic             istat,
  output logic             imask
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             pre_q, pre_d;
  logic [CMD_W-1:0] data_q, data_d;
  logic             istat_q, istat_d;
  logic             imask_q, imask_d;
  logic             start_q, start_d;
  logic             accept;

  assign accept = we && (addr == A_DATA) && !busy && !start_q;

  always_comb begin
    div_d   = div_q;
    pre_d   = pre_q;
    data_d  = data_q;
    istat_d = istat_q;
    imask_d = imask_q;
    start_d = accept;
    if (we && addr == A_CTRL) begin
      div_d = wdata[DIV_W-1:0];
      pre_d = wdata[DIV_W];
    end
    if (accept) data_d = wdata;
    if (done && done_rd) data_d[RD_W-1:0] = rx_data;
    if (we && addr == A_IMASK) imask_d = wdata[0];
    if (done) istat_d = 1'b1;
    else if (we && addr == A_ISTAT && wdata[0]) istat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      pre_q   <= 1'b0;
      data_q  <= '0;
      istat_q <= 1'b0;
      imask_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      pre_q   <= pre_d;
      data_q  <= data_d;
      istat_q <= istat_d;
      imask_q <= imask_d;
      start_q <= start_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  begin
        rdata[DIV_W-1:0] = div_q;
        rdata[DIV_W]     = pre_q;
      end
      A_DATA:  rdata = data_q;
      A_ISTAT: rdata[0] = istat_q;
      default: rdata[0] = imask_q;
    endcase
  end

  assign div    = div_q;
  assign pre_en = pre_q;
  assign cmd    = data_q;
  assign start  = start_q;
  assign istat  = istat_q;
  assign imask  = imask_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned CMD_W   = 32,
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned RD_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CMD_W-1:0] bus_wdata,
  output logic [CMD_W-1:0] bus_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i,
  output logic             irq
);
  logic [DIV_W-1:0] div_w;
  logic             pre_w, start_w, busy_w, done_w, done_rd_w;
  logic             tick_rise_w, tick_fall_w, istat_w, imask_w;
  logic [CMD_W-1:0] cmd_w;
  logic [RD_W-1:0]  rx_w;

  mdio_regs #(.DIV_W(DIV_W), .CMD_W(CMD_W), .RD_W(RD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy_w), .done(done_w),
    .done_rd(done_rd_w), .rx_data(rx_w), .div(div_w), .pre_en(pre_w),
    .cmd(cmd_w), .start(start_w), .istat(istat_w), .imask(imask_w)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .div(div_w), .mdc(mdc),
    .tick_rise(tick_rise_w), .tick_fall(tick_fall_w)
  );

  mdio_engine #(.CMD_W(CMD_W), .PRE_LEN(PRE_LEN), .RD_W(RD_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .pre_en(pre_w), .cmd(cmd_w),
    .tick_rise(tick_rise_w), .tick_fall(tick_fall_w), .mdio_i(mdio_i),
    .busy(busy_w), .done(done_w), .done_rd(done_rd_w), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rx_data(rx_w)
  );

  assign irq = istat_w & imask_w;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned CMD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             istat,
  input logic [CMD_W-1:0] cmd
);
  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r5_mdio_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o));
  a_r10_oe_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  a_r6_oe_no_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$rose(mdio_oe));
  a_r7_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> istat);
  a_r9_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd));
endmodule

bind mdio_master mdio_master_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy_w), .istat(istat_w), .cmd(cmd_w)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  import mdio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic        mdio_i = 1'b1;

  int n_checks = 0;
  int n_errors = 0;

  // PHY model and edge recorder
  int          n_rise = 0;
  int          pre_off = 0;
  logic [63:0] seen_o = '0;
  logic [63:0] seen_oe = '0;
  logic [15:0] phy_resp = '0;
  time         t_prev = 0;
  time         t_gap = 0;

  always #4 clk = !clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
  );

  always @(posedge mdc) begin
    int idx;
    seen_o  = {seen_o[62:0], mdio_o};
    seen_oe = {seen_oe[62:0], mdio_oe};
    t_gap   = $time - t_prev;
    t_prev  = $time;
    n_rise  = n_rise + 1;
    idx = n_rise - pre_off;
    if (idx >= 16 && idx <= 31) mdio_i = phy_resp[31-idx];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(A_ISTAT, v);
      if (v[0]) return;
    end
    chk("R7 completion timeout", 0, 1);
  endtask

  task automatic run_frame(input logic [31:0] cmd, input logic pre,
                           input logic [6:0] div, input logic [15:0] resp);
    reg_wr(A_ISTAT, 32'h1);
    reg_wr(A_CTRL, {24'h0, pre, div});
    n_rise = 0; seen_o = '0; seen_oe = '0; mdio_i = 1'b1;
    pre_off = pre ? 32 : 0; phy_resp = resp;
    reg_wr(A_DATA, cmd);
    wait_done();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 mdc low", mdc, 0);
    chk("R1 oe low", mdio_oe, 0);
    chk("R1 irq low", irq, 0);
  endtask

  task automatic t_write_plain();
    logic [31:0] cmd, v;
    cmd = {4'h5, 5'd3, 5'd4, 2'b10, 16'hA5C3};
    run_frame(cmd, 1'b0, 7'd0, 16'h0);
    chk("R3 edge count", n_rise, 32);
    chk("R3 bits on mdio", seen_o[31:0], cmd);
    chk("R3 oe during write", seen_oe[31:0], 32'hFFFF_FFFF);
    chk("R2 period div0 (ns)", t_gap, 16);
    reg_rd(A_DATA, v);
    chk("R3 data kept after write", v, cmd);
    chk("R10 oe idle after frame", mdio_oe, 0);
    chk("R2 mdc idle low", mdc, 0);
  endtask

  task automatic t_write_preamble();
    logic [31:0] cmd;
    cmd = {4'h5, 5'd17, 5'd31, 2'b10, 16'h1234};
    run_frame(cmd, 1'b1, 7'd3, 16'h0);
    chk("R4 edge count", n_rise, 64);
    chk("R4 preamble then command", seen_o, {32'hFFFF_FFFF, cmd});
    chk("R2 period div3 (ns)", t_gap, 64);
  endtask

  task automatic t_read(input logic pre, input logic [6:0] div, input logic [15:0] resp);
    logic [31:0] cmd, v;
    cmd = {4'h6, 5'd9, 5'd2, 2'b10, 16'h0000};
    run_frame(cmd, pre, div, resp);
    chk("R6 edge count", n_rise, pre ? 64 : 32);
    chk("R6 oe pattern", seen_oe[31:0], 32'hFFFE_0000);
    reg_rd(A_DATA, v);
    chk("R6 read data", v, {cmd[31:16], resp});
  endtask

  task automatic t_irq();
    logic [31:0] v;
    run_frame({4'h5, 5'd1, 5'd1, 2'b10, 16'h00FF}, 1'b0, 7'd1, 16'h0);
    chk("R8 irq masked", irq, 0);
    reg_wr(A_IMASK, 32'h1);
    chk("R8 irq unmasked", irq, 1);
    reg_wr(A_ISTAT, 32'h0);
    reg_rd(A_ISTAT, v);
    chk("R7 write 0 keeps flag", v[0], 1);
    reg_wr(A_ISTAT, 32'h1);
    reg_rd(A_ISTAT, v);
    chk("R7 write 1 clears flag", v[0], 0);
    chk("R8 irq after clear", irq, 0);
    reg_wr(A_IMASK, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] cmd_a, cmd_b, v;
    cmd_a = {4'h5, 5'd2, 5'd6, 2'b10, 16'hC0DE};
    cmd_b = {4'h6, 5'd30, 5'd29, 2'b10, 16'h5555};
    reg_wr(A_ISTAT, 32'h1);
    reg_wr(A_CTRL, 32'h2);
    n_rise = 0; seen_o = '0; pre_off = 0;
    reg_wr(A_DATA, cmd_a);
    repeat (6) @(negedge clk);
    reg_wr(A_DATA, cmd_b);
    wait_done();
    reg_rd(A_DATA, v);
    chk("R9 stored word kept", v, cmd_a);
    chk("R9 frame unchanged", seen_o[31:0], cmd_a);
    chk("R9 edge count", n_rise, 32);
  endtask

  initial begin
    #1000000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_plain();
    t_write_preamble();
    t_read(1'b0, 7'd0, 16'hBEEF);
    t_read(1'b1, 7'd1, 16'h8001);
    t_irq();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule